// File: doc/BRIEF.md
# Single-Wire Bus Bit-Slot Engine

This block is the timing core of a master for an open-drain single-wire bus. It takes one command at a time from a controller: a write-0 slot, a write-1 slot, a touch slot or a bus reset. For each command it produces a timed low pulse on an active-high pull-low output, which feeds an external open-drain buffer. It samples the bus through a synchronizer at a fixed point inside read and reset slots. It then waits out the recovery time and signals completion with a one-clock done pulse that carries the result bit. Byte assembly, ROM selection and strong pull-up control sit in neighbouring blocks.

All durations count in microsecond ticks. A divider derives these from the clock frequency parameter and restarts on every accepted command, so each phase lasts a whole number of ticks from the start of its slot. A small runtime coefficient stretches every phase by the same integer factor, which slows the whole bus down for long or heavily loaded lines.

Top module: `owm_slot_engine`

## Requirements
- R1: After reset, pull_low, busy and done are all 0.
- R2: Opcode 2'b01 (write-1) drives pull_low high for 6 µs, then releases for 64 µs, then pulses done with result 0.
- R3: Opcode 2'b00 (write-0) drives pull_low high for 60 µs, then releases for 10 µs, then pulses done with result 0.
- R4: Opcode 2'b10 (touch) with cmd_data 1 drives low for 6 µs and samples the synchronized bus 9 µs after release. It pulses done 55 µs after the sample, and result equals the sampled level.
- R5: Opcode 2'b10 with cmd_data 0 behaves exactly as a write-0 slot and returns result 0, whatever the bus level.
- R6: Opcode 2'b11 (reset) drives low for 500 µs and samples the bus 70 µs after release. Result 0 means a device pulled the line low (present) and result 1 means no device.
- R7: After the reset sample the engine stays busy for a further 430 µs, so a reset command takes 1000 µs from start to done.
- R8: Every phase lasts its nominal time multiplied by delay_coef. A coefficient of 0 acts as 1. A slot starts the cycle after acceptance, and each µs is CLK_HZ/1,000,000 clocks.
- R9: A command presented while busy is 1 is ignored: no slot starts from it, neither then nor later.
- R10: done is high for exactly one clock with result valid. busy is 0 in that clock, and a command presented then is accepted, so its low pulse starts in the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when busy is 0 |
| cmd_op | input | 2 | 00 write-0, 01 write-1, 10 touch, 11 bus reset |
| cmd_data | input | 1 | Touch bit: 1 read slot, 0 write-0 slot |
| delay_coef | input | COEF_W | Timing stretch factor, 0 treated as 1 |
| bus_in | input | 1 | Raw bus level, asynchronous |
| pull_low | output | 1 | High while the bus must be driven low |
| busy | output | 1 | A slot is in progress |
| done | output | 1 | One-clock completion strobe |
| result | output | 1 | Sampled level or presence result (0 = present) |

## Verification
The hardest situation to reach is a read slot in which a device holds the line low only for a short window near the sample instant. Only such a window shows whether sampling happens exactly 9 µs after release, rather than somewhere else in the slot. The bench models a responder that counts clocks from the release edge it sees on pull_low and pulls the bus low for a chosen window. The windows straddle the sample point, end before it, and begin after it. Command rejection while busy and acceptance in the done clock are reached by holding or pulsing cmd_valid during a slot in progress.

// File: rtl/owm_pkg.sv
package owm_pkg;

    typedef enum logic [1:0] {
        OP_WRITE0 = 2'b00,
        OP_WRITE1 = 2'b01,
        OP_TOUCH  = 2'b10,
        OP_RESET  = 2'b11
    } owm_op_e;

    typedef enum logic [1:0] {
        SLOT_W0,
        SLOT_W1,
        SLOT_RD,
        SLOT_RST
    } owm_slot_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_GAP,
        PH_REC
    } owm_phase_e;

    localparam int unsigned US_W       = 10;
    localparam int unsigned LONGEST_US = 500;

    // Nominal length in microseconds of each phase of each slot kind.
    function automatic logic [US_W-1:0] phase_us(owm_slot_e s, owm_phase_e p);
        logic [US_W-1:0] v;
        v = '0;
        unique case (s)
            SLOT_W1: v = (p == PH_LOW) ? 10'd6   : (p == PH_REC) ? 10'd64  : 10'd0;
            SLOT_W0: v = (p == PH_LOW) ? 10'd60  : (p == PH_REC) ? 10'd10  : 10'd0;
            SLOT_RD: v = (p == PH_LOW) ? 10'd6   : (p == PH_GAP) ? 10'd9   :
                         (p == PH_REC) ? 10'd55  : 10'd0;
            default: v = (p == PH_LOW) ? 10'd500 : (p == PH_GAP) ? 10'd70  :
                         (p == PH_REC) ? 10'd430 : 10'd0;
        endcase
        return v;
    endfunction

    function automatic logic slot_samples(owm_slot_e s);
        return (s == SLOT_RD) || (s == SLOT_RST);
    endfunction

    function automatic owm_slot_e decode_op(owm_op_e op, logic data);
        owm_slot_e s;
        unique case (op)
            OP_WRITE0: s = SLOT_W0;
            OP_WRITE1: s = SLOT_W1;
            OP_TOUCH:  s = data ? SLOT_RD : SLOT_W0;
            default:   s = SLOT_RST;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/owm_tick_gen.sv
module owm_tick_gen #(
    parameter int unsigned CLK_HZ = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned DIV  = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
    localparam int unsigned CW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int unsigned LAST = DIV - 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart || (cnt_q == CW'(LAST))) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = (cnt_q == CW'(LAST));

    generate
        if (DIV > 1) begin : g_div_chk
            // R8: ticks are spaced by the divider, never back to back
            p_tick_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/owm_sync.sv
module owm_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[STAGES-2:0], din};
    end

    // Idle bus level is high, so the chain resets to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '1;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign dout = sr_q[STAGES-1];

endmodule

// File: rtl/owm_slot_fsm.sv
module owm_slot_fsm
    import owm_pkg::*;
#(
    parameter int unsigned COEF_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_data,
    input  logic [COEF_W-1:0] delay_coef,
    input  logic              tick,
    input  logic              bus_s,
    output logic              start,
    output logic              pull_low,
    output logic              busy,
    output logic              done,
    output logic              result
);
    localparam int unsigned COEF_MAX = (1 << COEF_W) - 1;
    localparam int unsigned MAX_US   = LONGEST_US * COEF_MAX;
    localparam int unsigned CNT_W    = $clog2(MAX_US + 1);

    typedef struct packed {
        owm_phase_e        ph;
        owm_slot_e         slot;
        logic [COEF_W-1:0] coef;
        logic [CNT_W-1:0]  us;
        logic              smp;
        logic              done;
        logic              res;
    } fsm_t;

    fsm_t             d, q;
    logic [CNT_W-1:0] target;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        start  = 1'b0;
        target = CNT_W'(phase_us(q.slot, q.ph)) * CNT_W'(q.coef);
        unique case (q.ph)
            PH_IDLE: begin
                if (cmd_valid) begin
                    start  = 1'b1;
                    d.ph   = PH_LOW;
                    d.us   = '0;
                    d.smp  = 1'b0;
                    d.slot = decode_op(owm_op_e'(cmd_op), cmd_data);
                    d.coef = (delay_coef == '0) ? COEF_W'(1) : delay_coef;
                end
            end
            default: begin
                if (tick) begin
                    if (q.us == target - 1'b1) begin
                        d.us = '0;
                        unique case (q.ph)
                            PH_LOW: d.ph = slot_samples(q.slot) ? PH_GAP : PH_REC;
                            PH_GAP: begin
                                d.smp = bus_s;
                                d.ph  = PH_REC;
                            end
                            default: begin
                                d.ph   = PH_IDLE;
                                d.done = 1'b1;
                                d.res  = q.smp;
                            end
                        endcase
                    end else begin
                        d.us = q.us + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, slot: SLOT_W0, coef: COEF_W'(1), us: '0,
                   smp: 1'b0, done: 1'b0, res: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign pull_low = (q.ph == PH_LOW);
    assign busy     = (q.ph != PH_IDLE);
    assign done     = q.done;
    assign result   = q.res;

    // R10: completion strobe lasts a single clock
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: a done strobe only ever closes a running slot
    p_done_closes_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R9: a request while busy leaves the captured slot and coefficient alone
    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> ($stable(q.slot) && $stable(q.coef)));

    // R8: an accepted command starts its low pulse in the next clock
    p_start_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid) |=> pull_low);

    // R2: releasing the line always leaves a wait before completion
    p_release_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull_low) |-> (busy && !done));

    // R5: write slots never report a one
    p_write_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !slot_samples(q.slot)) |-> !result);

endmodule

// File: rtl/owm_slot_engine.sv
module owm_slot_engine #(
    parameter int unsigned CLK_HZ      = 100_000_000,
    parameter int unsigned COEF_W      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_data,
    input  logic [COEF_W-1:0] delay_coef,
    input  logic              bus_in,
    output logic              pull_low,
    output logic              busy,
    output logic              done,
    output logic              result
);
    logic tick;
    logic start;
    logic bus_s;

    owm_tick_gen #(
        .CLK_HZ (CLK_HZ)
    ) tick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .tick    (tick)
    );

    owm_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (bus_in),
        .dout  (bus_s)
    );

    owm_slot_fsm #(
        .COEF_W (COEF_W)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_data   (cmd_data),
        .delay_coef (delay_coef),
        .tick       (tick),
        .bus_s      (bus_s),
        .start      (start),
        .pull_low   (pull_low),
        .busy       (busy),
        .done       (done),
        .result     (result)
    );

endmodule

// File: tb/owm_slot_engine_tb_top.sv
module owm_slot_engine_tb_top;
    localparam int unsigned CLK_HZ = 4_000_000;
    localparam int          DIV    = 4;
    localparam int unsigned COEF_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'b00;
    logic              cmd_data = 1'b0;
    logic [COEF_W-1:0] delay_coef = 4'd1;
    logic              bus_in = 1'b1;
    logic              pull_low, busy, done, result;

    always #2.5 clk = ~clk;

    owm_slot_engine #(
        .CLK_HZ (CLK_HZ),
        .COEF_W (COEF_W)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_data   (cmd_data),
        .delay_coef (delay_coef),
        .bus_in     (bus_in),
        .pull_low   (pull_low),
        .busy       (busy),
        .done       (done),
        .result     (result)
    );

    typedef struct {
        int    lo;
        int    tot;
        bit    res;
        bit    chained;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails = 0;
    bit   finished = 0;

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Responder model: whole-slot hold or a window counted from release.
    bit dev_hold = 0;
    bit win_en = 0;
    int win_lo = 0;
    int win_hi = 0;
    int rel = 1000000;
    bit pl_prev = 0;

    always @(negedge clk) begin
        if (pl_prev && !pull_low) rel = 0;
        else rel = rel + 1;
        pl_prev = pull_low;
        bus_in = !(pull_low || dev_hold || (win_en && rel >= win_lo && rel < win_hi));
    end

    // Monitor: measures each slot and compares with the scoreboard head.
    int  cyc_g = 0;
    bit  active = 0;
    int  run = 0;
    int  lowc = 0;
    int  done_cyc = -10;

    always @(negedge clk) begin
        cyc_g++;
        if (rst_n) begin
            if (!active && pull_low) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R9", "slot started with nothing expected", 1, 0);
                end else begin
                    active = 1;
                    run = 0;
                    lowc = 0;
                    if (exp_q[0].chained)
                        chk(cyc_g == done_cyc + 1, "R10", "start clock after done",
                            cyc_g - done_cyc, 1);
                end
            end
            if (active) begin
                run++;
                if (pull_low) lowc++;
            end
            if (done) begin
                if (!active || exp_q.size() == 0) begin
                    chk(0, "R10", "done without a slot", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(lowc == e.lo, e.tag, "low clocks", lowc, e.lo);
                    chk(run - 1 == e.tot, e.tag, "slot clocks", run - 1, e.tot);
                    chk(result == e.res, e.tag, "result", int'(result), int'(e.res));
                end
                active = 0;
                done_cyc = cyc_g;
            end
        end
    end

    // Driver: pushes the expectation and presents one command.
    task automatic issue(logic [1:0] op, logic dat, int coef, int lo_us, int tot_us,
                         bit res, bit chained, string tag);
        exp_t e;
        int   c;
        c = (coef == 0) ? 1 : coef;
        e.lo = lo_us * c * DIV;
        e.tot = tot_us * c * DIV;
        e.res = res;
        e.chained = chained;
        e.tag = tag;
        exp_q.push_back(e);
        if (!chained) begin
            @(negedge clk);
            while (busy) @(negedge clk);
            cmd_op = op;
            cmd_data = dat;
            delay_coef = COEF_W'(coef);
            cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_cmd(logic [1:0] op, logic dat, int coef, int lo_us, int tot_us,
                           bit res, string tag);
        issue(op, dat, coef, lo_us, tot_us, res, 0, tag);
        drain();
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd == 150000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", wd);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state right after reset
        chk(pull_low == 0, "R1", "pull_low in reset", int'(pull_low), 0);
        chk(busy == 0, "R1", "busy in reset", int'(busy), 0);
        chk(done == 0, "R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(pull_low == 0 && busy == 0 && done == 0, "R1", "idle after reset",
            int'({pull_low, busy, done}), 0);

        // R6 R7: reset without and with a responding device
        run_cmd(2'b11, 0, 1, 500, 1000, 1, "R6_absent");
        dev_hold = 1;
        run_cmd(2'b11, 0, 1, 500, 1000, 0, "R6_R7_present");
        // R2: write-1 slot, bus held low changes nothing
        run_cmd(2'b01, 0, 1, 6, 70, 0, "R2");
        dev_hold = 0;
        // R3: write-0 slot
        run_cmd(2'b00, 1, 1, 60, 70, 0, "R3");
        // R4: touch-1 reads the level
        dev_hold = 1;
        run_cmd(2'b10, 1, 1, 6, 70, 0, "R4_low");
        dev_hold = 0;
        run_cmd(2'b10, 1, 1, 6, 70, 1, "R4_high");
        // R4: narrow device windows around the 9 us sample point
        win_en = 1;
        win_lo = 8 * DIV; win_hi = 10 * DIV;
        run_cmd(2'b10, 1, 1, 6, 70, 0, "R4_window_on_sample");
        win_lo = 0; win_hi = 7 * DIV;
        run_cmd(2'b10, 1, 1, 6, 70, 1, "R4_window_early");
        win_lo = 11 * DIV; win_hi = 15 * DIV;
        run_cmd(2'b10, 1, 1, 6, 70, 1, "R4_window_late");
        win_en = 0;
        // R5: touch-0 is a write-0 returning 0 on a high bus
        run_cmd(2'b10, 0, 1, 60, 70, 0, "R5");
        // R8: coefficient scaling and zero coefficient
        run_cmd(2'b01, 0, 3, 6, 70, 0, "R8_coef3");
        run_cmd(2'b00, 0, 0, 60, 70, 0, "R8_coef0");
        dev_hold = 1;
        run_cmd(2'b11, 0, 2, 500, 1000, 0, "R8_reset_coef2");
        dev_hold = 0;
        win_en = 1;
        win_lo = 17 * DIV; win_hi = 19 * DIV;
        run_cmd(2'b10, 1, 2, 6, 70, 0, "R8_read_coef2");
        win_en = 0;

        // R9: a reset request during a write-1 slot is dropped
        issue(2'b01, 0, 1, 6, 70, 0, 0, "R9_slot");
        repeat (20) @(negedge clk);
        cmd_op = 2'b11; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        drain();
        repeat (200) @(negedge clk);
        chk(busy == 0 && pull_low == 0, "R9", "idle after ignored request",
            int'({busy, pull_low}), 0);

        // R10: request held through a slot is taken in the done clock
        issue(2'b01, 0, 1, 6, 70, 0, 0, "R10_first");
        cmd_valid = 1'b1;
        issue(2'b01, 0, 1, 6, 70, 0, 1, "R10_second");
        while (!done) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        drain();
        chk(exp_q.size() == 0, "R10", "scoreboard drained", exp_q.size(), 0);

        if (!finished) begin
            finished = 1;
            summary();
            $finish;
        end
    end

endmodule